// File: doc/BRIEF.md
# Tagged Transmit Byte Queue with Emptying Threshold

This block sits between a processor write port and a serial transmitter. The processor pushes bytes into it, and the transmitter pops them one at a time. Each stored entry holds a data byte and two marker bits. The end-of-packet marker says the byte closes a packet. The abort marker says the transmitter should send an abort sequence in place of that byte.

The processor does not send the markers with each byte. It first sets them in a small control register, and then it writes the final byte of the packet. Each accepted byte write copies the current marker bits into that entry and then clears them. The same control register also chooses one of two emptying thresholds. The queue reports a 2-bit fill code at all times. It pulses a low-water event when the number of stored bytes falls from above the active threshold to at or below it, which lets the processor refill before the transmitter runs dry. Everything runs on one clock.

Top module: `txq_tag_fifo`

## Requirements
- R1: After reset the queue holds no bytes. The fill code is 00, both marker bits are clear, the low threshold is active, and all read outputs and event pulses are 0.
- R2: Bytes come out in the order they were accepted. A pop in cycle N presents the byte on rd_data in cycle N+1, and rd_data holds that value until the next pop.
- R3: The queue stores 19 entries. A write while 19 entries are held is dropped, leaves the level and the marker bits unchanged, and gives a one-cycle wr_overflow pulse in the next cycle.
- R4: A pop while the queue is empty leaves rd_data, rd_eop and rd_abort unchanged and gives a one-cycle rd_underrun pulse in the next cycle.
- R5: Each accepted write stores the marker bits as they stood before that cycle. They come out on rd_eop and rd_abort together with the byte.
- R6: Every accepted write clears both marker bits. A control write in the same cycle wins: the entry gets the old markers, and the marker bits then take the newly written values. A dropped write clears nothing.
- R7: On a control write, ctl_thr_hi selects the threshold: 0 gives a level of 4 and 1 gives a level of 14. The new threshold applies from the next cycle.
- R8: fill_code is 00 when 0 entries are held, 01 for 1 up to the threshold, 10 from the threshold plus one up to 18, and 11 when 19 entries are held.
- R9: low_evt pulses for one cycle, in the cycle after the level falls from above the active threshold to at or below it. It stays low while the level stays below, while the level rises, and when only the threshold setting changes.
- R10: A push and a pop in the same cycle are both performed and the level is unchanged. When the queue is full, the write is dropped and the pop still happens. When it is empty, the write is stored and the pop is flagged as an underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_eop | input | 1 | End-of-packet marker value to load |
| ctl_abort | input | 1 | Abort marker value to load |
| ctl_thr_hi | input | 1 | Threshold select to load (0 = 4, 1 = 14) |
| tag_eop_q | output | 1 | Current end-of-packet marker bit |
| tag_abort_q | output | 1 | Current abort marker bit |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Pop strobe from the transmitter |
| rd_data | output | 8 | Last popped byte |
| rd_eop | output | 1 | End-of-packet marker of the last popped byte |
| rd_abort | output | 1 | Abort marker of the last popped byte |
| fill_level | output | 5 | Number of entries held |
| fill_code | output | 2 | Coded fill state |
| low_evt | output | 1 | Low-water event pulse |
| wr_overflow | output | 1 | Dropped-write pulse |
| rd_underrun | output | 1 | Empty-pop pulse |

## Verification
The first pattern is short packets whose markers are set in different ways: end of packet, abort, and a control write in the same cycle as the data write. It shows whether the markers are captured, cleared and aligned with their own bytes rather than a neighbour's. The second pattern fills the queue to the top and then drains it below empty. This separates an off-by-one at the full and empty edges, and a low-water event at the wrong level or from the wrong direction, from correct behaviour. The third pattern repeats the drain with the high threshold and flips the threshold at a fixed level. This shows that the event follows changes in the level and not changes in the setting. The last pattern holds push and pop together in the middle, at full and at empty, which exposes any asymmetry between the two accept paths.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef enum logic [1:0] {
      FILL_EMPTY = 2'b00,
      FILL_LOW   = 2'b01,
      FILL_MID   = 2'b10,
      FILL_FULL  = 2'b11
   } fill_code_e;

   // marker bit positions above the data byte in a stored word
   localparam int MK_EOP_OFS   = 1;
   localparam int MK_ABORT_OFS = 0;
   localparam int MK_BITS      = 2;
endpackage

// File: rtl/txq_tagctl.sv
module txq_tagctl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_eop,
   input  logic ctl_abort,
   input  logic ctl_thr_hi,
   input  logic push_ok,
   output logic eop_q,
   output logic abort_q,
   output logic thr_hi_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eop_q    <= 1'b0;
         abort_q  <= 1'b0;
         thr_hi_q <= 1'b0;
      end else if (ctl_wr) begin
         eop_q    <= ctl_eop;
         abort_q  <= ctl_abort;
         thr_hi_q <= ctl_thr_hi;
      end else if (push_ok) begin
         eop_q    <= 1'b0;
         abort_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DEPTH = 19,
   parameter int EW    = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_ok,
   input  logic          pop_ok,
   input  logic [EW-1:0] push_word,
   output logic [EW-1:0] pop_word
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [EW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;

   generate
      if (POW2) begin : g_wrap_nat
         always_comb begin
            wptr_nx = wptr + AW'(1);
            rptr_nx = rptr + AW'(1);
         end
      end else begin : g_wrap_cmp
         always_comb begin
            wptr_nx = (wptr == LAST) ? '0 : wptr + AW'(1);
            rptr_nx = (rptr == LAST) ? '0 : rptr + AW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= push_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr     <= '0;
         rptr     <= '0;
         pop_word <= '0;
      end else begin
         if (push_ok) wptr <= wptr_nx;
         if (pop_ok) begin
            rptr     <= rptr_nx;
            pop_word <= mem[rptr];
         end
      end
   end
endmodule

// File: rtl/txq_level.sv
module txq_level
   import txq_pkg::*;
#(
   parameter int DEPTH  = 19,
   parameter int THR_LO = 4,
   parameter int THR_HI = 14
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_req,
   input  logic                       pop_req,
   input  logic                       thr_hi,
   output logic                       push_ok,
   output logic                       pop_ok,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output fill_code_e                 code,
   output logic                       low_evt,
   output logic                       ovf,
   output logic                       und
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_LV = CW'(DEPTH);

   logic [CW-1:0] thr, lv_nx;
   logic          is_full, is_empty;

   assign thr      = thr_hi ? CW'(THR_HI) : CW'(THR_LO);
   assign is_full  = (level == FULL_LV);
   assign is_empty = (level == '0);
   assign push_ok  = push_req && !is_full;
   assign pop_ok   = pop_req && !is_empty;

   always_comb begin
      lv_nx = level;
      if (push_ok && !pop_ok) lv_nx = level + CW'(1);
      if (pop_ok && !push_ok) lv_nx = level - CW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level   <= '0;
         low_evt <= 1'b0;
         ovf     <= 1'b0;
         und     <= 1'b0;
      end else begin
         level   <= lv_nx;
         low_evt <= (level > thr) && (lv_nx <= thr);
         ovf     <= push_req && is_full;
         und     <= pop_req && is_empty;
      end
   end

   always_comb begin
      if (is_empty)        code = FILL_EMPTY;
      else if (is_full)    code = FILL_FULL;
      else if (level > thr) code = FILL_MID;
      else                 code = FILL_LOW;
   end
endmodule

// File: rtl/txq_tag_fifo.sv
module txq_tag_fifo
   import txq_pkg::*;
#(
   parameter int DEPTH  = 19,
   parameter int DW     = 8,
   parameter int THR_LO = 4,
   parameter int THR_HI = 14
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ctl_wr,
   input  logic                       ctl_eop,
   input  logic                       ctl_abort,
   input  logic                       ctl_thr_hi,
   output logic                       tag_eop_q,
   output logic                       tag_abort_q,
   input  logic                       wr_en,
   input  logic [DW-1:0]              wr_data,
   input  logic                       rd_en,
   output logic [DW-1:0]              rd_data,
   output logic                       rd_eop,
   output logic                       rd_abort,
   output logic [$clog2(DEPTH+1)-1:0] fill_level,
   output logic [1:0]                 fill_code,
   output logic                       low_evt,
   output logic                       wr_overflow,
   output logic                       rd_underrun
);
   localparam int EW = DW + MK_BITS;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txq_tag_fifo: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("txq_tag_fifo: DW must be at least 1");
      end
      if (THR_LO < 1 || THR_LO >= THR_HI) begin : g_bad_lo
         $error("txq_tag_fifo: need 1 <= THR_LO < THR_HI");
      end
      if (THR_HI >= DEPTH) begin : g_bad_hi
         $error("txq_tag_fifo: THR_HI must be below DEPTH");
      end
   endgenerate

   logic          push_ok, pop_ok, thr_hi_q;
   logic [EW-1:0] push_word, pop_word;
   fill_code_e    code;

   txq_tagctl u_tagctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .ctl_eop    (ctl_eop),
      .ctl_abort  (ctl_abort),
      .ctl_thr_hi (ctl_thr_hi),
      .push_ok    (push_ok),
      .eop_q      (tag_eop_q),
      .abort_q    (tag_abort_q),
      .thr_hi_q   (thr_hi_q)
   );

   txq_level #(.DEPTH(DEPTH), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (wr_en),
      .pop_req  (rd_en),
      .thr_hi   (thr_hi_q),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .level    (fill_level),
      .code     (code),
      .low_evt  (low_evt),
      .ovf      (wr_overflow),
      .und      (rd_underrun)
   );

   always_comb begin
      push_word                       = '0;
      push_word[DW+MK_EOP_OFS]        = tag_eop_q;
      push_word[DW+MK_ABORT_OFS]      = tag_abort_q;
      push_word[DW-1:0]               = wr_data;
   end

   txq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_ok   (push_ok),
      .pop_ok    (pop_ok),
      .push_word (push_word),
      .pop_word  (pop_word)
   );

   assign rd_data   = pop_word[DW-1:0];
   assign rd_eop    = pop_word[DW+MK_EOP_OFS];
   assign rd_abort  = pop_word[DW+MK_ABORT_OFS];
   assign fill_code = code;
endmodule

// File: rtl/txq_tag_fifo_chk.sv
module txq_tag_fifo_chk #(
   parameter int DEPTH  = 19,
   parameter int DW     = 8,
   parameter int THR_LO = 4,
   parameter int THR_HI = 14
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       ctl_wr,
   input logic                       thr_hi_q,
   input logic                       tag_eop_q,
   input logic                       tag_abort_q,
   input logic                       wr_en,
   input logic                       rd_en,
   input logic [DW-1:0]              rd_data,
   input logic [$clog2(DEPTH+1)-1:0] fill_level,
   input logic [1:0]                 fill_code,
   input logic                       low_evt,
   input logic                       wr_overflow,
   input logic                       rd_underrun
);
   localparam int CW = $clog2(DEPTH + 1);
   logic [CW-1:0] thr_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) thr_prev <= CW'(THR_LO);
      else        thr_prev <= thr_hi_q ? CW'(THR_HI) : CW'(THR_LO);
   end

   p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= CW'(DEPTH));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fill_level == CW'(DEPTH)) |=> wr_overflow);

   p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && fill_level == CW'(DEPTH)) |=> fill_level == CW'(DEPTH));

   p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && fill_level == '0) |=> (rd_underrun && $stable(rd_data)));

   p_tag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ctl_wr && fill_level < CW'(DEPTH)) |=> (!tag_eop_q && !tag_abort_q));

   p_code_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((fill_code == 2'b11) == (fill_level == CW'(DEPTH))) &&
      ((fill_code == 2'b00) == (fill_level == '0)));

   p_low_cross_r9: assert property (@(posedge clk) disable iff (!rst_n)
      low_evt |-> (fill_level <= thr_prev && $past(fill_level) > thr_prev));

   p_low_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      low_evt |=> !low_evt);
endmodule

bind txq_tag_fifo txq_tag_fifo_chk #(
   .DEPTH(DEPTH), .DW(DW), .THR_LO(THR_LO), .THR_HI(THR_HI)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_wr      (ctl_wr),
   .thr_hi_q    (thr_hi_q),
   .tag_eop_q   (tag_eop_q),
   .tag_abort_q (tag_abort_q),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .rd_data     (rd_data),
   .fill_level  (fill_level),
   .fill_code   (fill_code),
   .low_evt     (low_evt),
   .wr_overflow (wr_overflow),
   .rd_underrun (rd_underrun)
);

// File: tb/txq_tag_fifo_tb.sv
module txq_tag_fifo_tb;
   localparam int D = 19;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 0, ctl_eop = 0, ctl_abort = 0, ctl_thr_hi = 0;
   logic       wr_en = 0, rd_en = 0;
   logic [7:0] wr_data = '0;
   logic       tag_eop_q, tag_abort_q, rd_eop, rd_abort;
   logic [7:0] rd_data;
   logic [4:0] fill_level;
   logic [1:0] fill_code;
   logic       low_evt, wr_overflow, rd_underrun;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference model state
   logic [9:0] q[$];
   bit         m_eop = 0, m_ab = 0, m_hi = 0;
   logic [7:0] m_rd = 0;
   bit         m_rdeop = 0, m_rdab = 0, m_low = 0, m_ovf = 0, m_und = 0;

   always #4 clk = ~clk;

   txq_tag_fifo u_dut (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_eop(ctl_eop), .ctl_abort(ctl_abort), .ctl_thr_hi(ctl_thr_hi),
      .tag_eop_q(tag_eop_q), .tag_abort_q(tag_abort_q),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .rd_eop(rd_eop), .rd_abort(rd_abort),
      .fill_level(fill_level), .fill_code(fill_code),
      .low_evt(low_evt), .wr_overflow(wr_overflow), .rd_underrun(rd_underrun)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int thr_now();
      return m_hi ? 14 : 4;
   endfunction

   function automatic int code_of(input int n);
      if (n == 0) return 0;
      if (n == D) return 3;
      if (n > thr_now()) return 2;
      return 1;
   endfunction

   task automatic compare_all();
      int n = q.size();
      check(fill_level == n, "R10", "fill_level", fill_level, n);
      check(fill_code == code_of(n), "R8", "fill_code", fill_code, code_of(n));
      check(rd_data == m_rd, "R2", "rd_data", rd_data, m_rd);
      check(rd_eop == m_rdeop && rd_abort == m_rdab, "R5", "rd markers",
            {rd_eop, rd_abort}, {m_rdeop, m_rdab});
      check(tag_eop_q == m_eop && tag_abort_q == m_ab, "R6", "marker bits",
            {tag_eop_q, tag_abort_q}, {m_eop, m_ab});
      check(low_evt == m_low, "R9", "low_evt", low_evt, m_low);
      check(wr_overflow == m_ovf, "R3", "wr_overflow", wr_overflow, m_ovf);
      check(rd_underrun == m_und, "R4", "rd_underrun", rd_underrun, m_und);
   endtask

   // drive one cycle from a negedge, advance the model, compare at next negedge
   task automatic cyc(input bit w, input logic [7:0] d, input bit r,
                      input bit cw = 0, input bit ce = 0, input bit ca = 0,
                      input bit ch = 0);
      int  old = q.size();
      int  thr = thr_now();
      bit  aw = w && (old < D);
      bit  ar = r && (old > 0);
      logic [9:0] e;
      wr_en = w; wr_data = d; rd_en = r;
      ctl_wr = cw; ctl_eop = ce; ctl_abort = ca; ctl_thr_hi = ch;
      m_ovf = w && (old == D);
      m_und = r && (old == 0);
      if (ar) begin
         e = q.pop_front();
         m_rd = e[7:0]; m_rdeop = e[9]; m_rdab = e[8];
      end
      if (aw) q.push_back({m_eop, m_ab, d});
      if (cw) begin m_eop = ce; m_ab = ca; end
      else if (aw) begin m_eop = 0; m_ab = 0; end
      m_low = (old > thr) && (q.size() <= thr);
      if (cw) m_hi = ch;
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; rd_en = 0; ctl_wr = 0;
      compare_all();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all-requirements actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(fill_level == 0 && fill_code == 0, "R1", "empty after reset", fill_level, 0);
      check(!tag_eop_q && !tag_abort_q, "R1", "markers after reset", {tag_eop_q, tag_abort_q}, 0);
      check(rd_data == 0 && !low_evt && !wr_overflow && !rd_underrun, "R1", "outputs after reset",
            rd_data, 0);

      // R5 R6: packet with end marker, then one with abort marker
      cyc(1, 8'h11, 0);
      cyc(1, 8'h22, 0);
      cyc(0, 0, 0, 1, 1, 0, 0);
      cyc(1, 8'h33, 0);
      cyc(0, 0, 0, 1, 0, 1, 0);
      cyc(1, 8'h44, 0);
      // R6 control write in the same cycle as a data write
      cyc(0, 0, 0, 1, 1, 0, 0);
      cyc(1, 8'h55, 0, 1, 0, 1, 0);
      check(tag_abort_q == 1 && tag_eop_q == 0, "R6", "same-cycle ctl wins", tag_abort_q, 1);
      cyc(1, 8'h66, 0);
      for (int i = 0; i < 6; i++) cyc(0, 0, 1);
      check(rd_data == 8'h66 && rd_abort == 1, "R5", "abort marker rides with byte", rd_abort, 1);
      // R4 pop while empty
      cyc(0, 0, 1);
      check(rd_underrun == 1 && rd_data == 8'h66, "R4", "empty pop holds data", rd_data, 8'h66);

      // R3 fill to full, overflow, R10 full push+pop
      for (int i = 0; i < D; i++) cyc(1, 8'(8'h80 + i), 0);
      check(fill_code == 2'b11, "R8", "full code", fill_code, 3);
      cyc(0, 0, 0, 1, 1, 1, 0);
      cyc(1, 8'hEE, 0);
      check(wr_overflow == 1 && fill_level == D, "R3", "dropped write", fill_level, D);
      check(tag_eop_q && tag_abort_q, "R3", "dropped write keeps markers", tag_eop_q, 1);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(1, 8'hEF, 1);
      check(fill_level == D - 1, "R10", "full push+pop", fill_level, D - 1);
      // drain with low threshold; R9 event at 5 -> 4
      for (int i = 0; i < D - 1; i++) cyc(0, 0, 1);
      cyc(1, 8'hA0, 1);
      check(fill_level == 1 && rd_underrun, "R10", "empty push+pop", fill_level, 1);
      cyc(0, 0, 1);

      // R7 high threshold: event at 15 -> 14
      cyc(0, 0, 0, 1, 0, 0, 1);
      for (int i = 0; i < 16; i++) cyc(1, 8'(i), 0);
      cyc(0, 0, 1);
      cyc(0, 0, 1);
      check(low_evt == 1 && fill_level == 14, "R7", "event at level 14", low_evt, 1);
      cyc(1, 8'hB0, 1);
      cyc(0, 0, 1);
      // R9 threshold change alone raises nothing
      for (int i = 0; i < 3; i++) cyc(0, 0, 1);
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 1);
      check(low_evt == 0, "R9", "no event on setting change", low_evt, 0);
      for (int i = 0; i < 12; i++) cyc(0, 0, 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule